// File: doc/BRIEF.md
# Model-Configurable Processor Status Register

This block holds the 32-bit status and control word of a processor core. It keeps the arithmetic condition flags, the trap, interrupt-enable and direction controls, the two-bit I/O privilege field and the nested-task bit. A static model-level input picks one of four core generations: 0 is a legacy 16-bit core, 1 is a protected 16-bit core, 2 is a 32-bit core, and 3 is a 32-bit core that adds the alignment-check bit and an identification bit.

Four sources can write the word. A masked ALU update writes the condition flags. Direction commands clear or set the direction flag. A byte path moves the low eight bits in and out. A full-word path loads and stores 16 or 32 bits for stack save and restore. Every write passes through a per-level filter that forces fixed bits and drops writes to protected bits. The same filter is applied on read. Because of this, software can find the core generation by writing a bit and checking whether it stays set.

Top module: `cpu_status_reg`

## Requirements
- R1: A synchronous reset loads 0x00000002 with the level's forced bits applied. This gives 0x0000F002 at level 0 and 0x00000002 at levels 1 to 3.
- R2: Bit 1 always reads as 1. Bits 3, 5 and 31:22 always read as 0, whatever value is written.
- R3: At level 0, bits 15:12 always read as 1 and writes to them are ignored.
- R4: At levels 1 to 3, bit 15 reads as 0. Bits 14:12 (privilege field at 13:12, nested task at 14) hold written values.
- R5: At levels 0 and 1, bits 31:16 read as 0. At levels 2 and 3, bits 16, 17, 19 and 20 hold written values.
- R6: The alignment-check bit (18) and the identification bit (21) hold written values only at level 3. At other levels they read 0.
- R7: The clear-direction command makes bit 10 equal to 0 and the set-direction command makes it 1. If both are asserted in the same cycle, set wins.
- R8: A byte load replaces bits 7:0 only, filtered the same way as other writes. The byte store output equals bits 7:0 of the register.
- R9: A word load with the wide select low replaces bits 15:0 only. With the wide select high it replaces bits 31:0.
- R10: alu_mask bit i selects flag i. The order is bit 0 carry (reg bit 0), bit 1 parity (bit 2, 1 = even), bit 2 auxiliary carry (bit 4), bit 3 zero (bit 6, 1 = zero result), bit 4 sign (bit 7) and bit 5 overflow (bit 11). Selected flags take the alu_flags value and unselected flags keep their value.
- R11: Only one source writes in a cycle. The order from highest to lowest is word load, byte load, direction command, ALU update. With no command active the register holds its value.
- R12: The word store output equals the register. Storing the word, XORing it with 0x0400 and loading it back as 32 bits changes only bit 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| model_lvl | input | 2 | Static core generation level 0..3 |
| alu_mask | input | 6 | Per-flag update select from the ALU |
| alu_flags | input | 6 | New flag values from the ALU |
| dir_clr | input | 1 | Clear direction flag |
| dir_set | input | 1 | Set direction flag |
| byte_ld | input | 1 | Load low byte |
| byte_ld_data | input | 8 | Low byte load value |
| byte_st_data | output | 8 | Low byte of the register |
| word_ld | input | 1 | Load word |
| word_wide | input | 1 | 1: 32-bit load, 0: 16-bit load |
| word_ld_data | input | 32 | Word load value |
| word_st_data | output | 32 | Full register value |

## Verification
Every write command is taken at one rising edge. Both store outputs are combinational from the register, so each result can be read in the cycle after the command. The bench drives a command on a falling edge, holds it across exactly one rising edge, and releases it on the next falling edge. It samples the stores there, so each check sees exactly one update. The reset value is sampled on the first falling edge after reset is released.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int unsigned PSR_W    = 32;
    localparam int unsigned HALF_W   = 16;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned ALU_NF   = 6;
    localparam int unsigned LVL_W    = 2;

    typedef logic [PSR_W-1:0] psr_word_t;

    typedef enum logic [LVL_W-1:0] {
        LVL_LEGACY16  = 2'd0,
        LVL_PROT16    = 2'd1,
        LVL_CORE32    = 2'd2,
        LVL_CORE32_AC = 2'd3
    } core_lvl_e;

    // Flag positions that downstream decode depends on
    localparam int unsigned POS_CF   = 0;
    localparam int unsigned POS_ONE  = 1;
    localparam int unsigned POS_PF   = 2;
    localparam int unsigned POS_AF   = 4;
    localparam int unsigned POS_ZF   = 6;
    localparam int unsigned POS_SF   = 7;
    localparam int unsigned POS_TF   = 8;
    localparam int unsigned POS_IE   = 9;
    localparam int unsigned POS_DF   = 10;
    localparam int unsigned POS_OF   = 11;
    localparam int unsigned POS_PRV0 = 12;
    localparam int unsigned POS_PRV1 = 13;
    localparam int unsigned POS_NT   = 14;
    localparam int unsigned POS_B15  = 15;
    localparam int unsigned POS_X16  = 16;
    localparam int unsigned POS_X17  = 17;
    localparam int unsigned POS_ALN  = 18;
    localparam int unsigned POS_X19  = 19;
    localparam int unsigned POS_X20  = 20;
    localparam int unsigned POS_IDB  = 21;

    function automatic psr_word_t bit_at(int unsigned p);
        return psr_word_t'(1) << p;
    endfunction

    localparam psr_word_t BASE_RW = bit_at(POS_CF) | bit_at(POS_PF) | bit_at(POS_AF)
                                  | bit_at(POS_ZF) | bit_at(POS_SF) | bit_at(POS_TF)
                                  | bit_at(POS_IE) | bit_at(POS_DF) | bit_at(POS_OF);
    localparam psr_word_t SYS16_RW = bit_at(POS_PRV0) | bit_at(POS_PRV1) | bit_at(POS_NT);
    localparam psr_word_t EXT32_RW = bit_at(POS_X16) | bit_at(POS_X17)
                                   | bit_at(POS_X19) | bit_at(POS_X20);
    localparam psr_word_t L3_RW    = bit_at(POS_ALN) | bit_at(POS_IDB);
    localparam psr_word_t LEGACY_ONES = SYS16_RW | bit_at(POS_B15);
    localparam psr_word_t RESET_RAW   = bit_at(POS_ONE);

    // Register position of ALU flag lane i
    function automatic int unsigned alu_flag_pos(int unsigned i);
        case (i)
            0: return POS_CF;
            1: return POS_PF;
            2: return POS_AF;
            3: return POS_ZF;
            4: return POS_SF;
            default: return POS_OF;
        endcase
    endfunction

    function automatic psr_word_t lvl_writable(core_lvl_e l);
        psr_word_t m;
        m = BASE_RW;
        if (l != LVL_LEGACY16) m = m | SYS16_RW;
        if (l == LVL_CORE32 || l == LVL_CORE32_AC) m = m | EXT32_RW;
        if (l == LVL_CORE32_AC) m = m | L3_RW;
        return m;
    endfunction

    function automatic psr_word_t lvl_forced(core_lvl_e l);
        psr_word_t m;
        m = bit_at(POS_ONE);
        if (l == LVL_LEGACY16) m = m | LEGACY_ONES;
        return m;
    endfunction

    typedef struct packed {
        logic                word_ld;
        logic                word_wide;
        psr_word_t           word_data;
        logic                byte_ld;
        logic [BYTE_W-1:0]   byte_data;
        logic                dir_clr;
        logic                dir_set;
        logic [ALU_NF-1:0]   alu_mask;
    } psr_cmd_t;

endpackage

// File: rtl/psr_model_filter.sv
module psr_model_filter
    import psr_pkg::*;
(
    input  core_lvl_e lvl,
    input  psr_word_t raw,
    output psr_word_t clean
);
    psr_word_t wr_m;
    psr_word_t one_m;

    always_comb begin
        wr_m  = lvl_writable(lvl);
        one_m = lvl_forced(lvl);
    end

    for (genvar b = 0; b < PSR_W; b++) begin : g_bit
        assign clean[b] = one_m[b] | (raw[b] & wr_m[b]);
    end
endmodule

// File: rtl/psr_alu_merge.sv
module psr_alu_merge
    import psr_pkg::*;
(
    input  psr_word_t         cur,
    input  logic [ALU_NF-1:0] mask,
    input  logic [ALU_NF-1:0] flags,
    output psr_word_t         merged
);
    psr_word_t sel_m;
    psr_word_t val_m;

    for (genvar i = 0; i < ALU_NF; i++) begin : g_lane
        localparam int unsigned P = alu_flag_pos(i);
        assign sel_m[P] = mask[i];
        assign val_m[P] = flags[i];
    end

    // Non-flag lanes are never selected
    for (genvar b = 0; b < PSR_W; b++) begin : g_fill
        if (b != POS_CF && b != POS_PF && b != POS_AF &&
            b != POS_ZF && b != POS_SF && b != POS_OF) begin : g_nf
            assign sel_m[b] = 1'b0;
            assign val_m[b] = 1'b0;
        end
    end

    assign merged = (cur & ~sel_m) | (val_m & sel_m);
endmodule

// File: rtl/psr_src_sel.sv
module psr_src_sel
    import psr_pkg::*;
(
    input  psr_cmd_t  cmd,
    input  psr_word_t cur,
    input  psr_word_t alu_merged,
    output psr_word_t nxt
);
    always_comb begin
        nxt = cur;
        if (cmd.word_ld) begin
            if (cmd.word_wide)
                nxt = cmd.word_data;
            else
                nxt = {cur[PSR_W-1:HALF_W], cmd.word_data[HALF_W-1:0]};
        end else if (cmd.byte_ld) begin
            nxt = {cur[PSR_W-1:BYTE_W], cmd.byte_data};
        end else if (cmd.dir_clr || cmd.dir_set) begin
            nxt[POS_DF] = cmd.dir_set;
        end else if (|cmd.alu_mask) begin
            nxt = alu_merged;
        end
    end
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
    import psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        model_lvl,
    input  logic [5:0]        alu_mask,
    input  logic [5:0]        alu_flags,
    input  logic              dir_clr,
    input  logic              dir_set,
    input  logic              byte_ld,
    input  logic [7:0]        byte_ld_data,
    output logic [7:0]        byte_st_data,
    input  logic              word_ld,
    input  logic              word_wide,
    input  logic [31:0]       word_ld_data,
    output logic [31:0]       word_st_data
);
    core_lvl_e lvl;
    psr_cmd_t  cmd;
    psr_word_t state_q;
    psr_word_t alu_w;
    psr_word_t nxt_raw;
    psr_word_t nxt_clean;
    psr_word_t rst_clean;
    psr_word_t view;

    assign lvl = core_lvl_e'(model_lvl);

    always_comb begin
        cmd.word_ld   = word_ld;
        cmd.word_wide = word_wide;
        cmd.word_data = word_ld_data;
        cmd.byte_ld   = byte_ld;
        cmd.byte_data = byte_ld_data;
        cmd.dir_clr   = dir_clr;
        cmd.dir_set   = dir_set;
        cmd.alu_mask  = alu_mask;
    end

    psr_alu_merge u_alu (
        .cur    (state_q),
        .mask   (alu_mask),
        .flags  (alu_flags),
        .merged (alu_w)
    );

    psr_src_sel u_sel (
        .cmd        (cmd),
        .cur        (state_q),
        .alu_merged (alu_w),
        .nxt        (nxt_raw)
    );

    psr_model_filter u_wr_filt (.lvl(lvl), .raw(nxt_raw),   .clean(nxt_clean));
    psr_model_filter u_rs_filt (.lvl(lvl), .raw(RESET_RAW), .clean(rst_clean));
    psr_model_filter u_rd_filt (.lvl(lvl), .raw(state_q),   .clean(view));

    always_ff @(posedge clk) begin
        if (rst) state_q <= rst_clean;
        else     state_q <= nxt_clean;
    end

    assign word_st_data = view;
    assign byte_st_data = view[BYTE_W-1:0];

    // ---------------- assertions ----------------
    assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (rst)
        word_st_data[1] && !word_st_data[3] && !word_st_data[5] && word_st_data[31:22] == '0);

    assert_legacy_high_R3: assert property (@(posedge clk) disable iff (rst)
        (model_lvl == 2'd0) |-> word_st_data[15:12] == 4'hF);

    assert_prot_b15_R4: assert property (@(posedge clk) disable iff (rst)
        (model_lvl != 2'd0) |-> !word_st_data[15]);

    assert_narrow_upper_R5: assert property (@(posedge clk) disable iff (rst)
        (model_lvl < 2'd2) |-> word_st_data[31:16] == '0);

    assert_l3_only_bits_R6: assert property (@(posedge clk) disable iff (rst)
        (model_lvl != 2'd3) |-> (!word_st_data[18] && !word_st_data[21]));

    assert_dir_set_R7: assert property (@(posedge clk) disable iff (rst)
        (dir_set && !word_ld && !byte_ld) |=> word_st_data[10]);

    assert_dir_clr_R7: assert property (@(posedge clk) disable iff (rst)
        (dir_clr && !dir_set && !word_ld && !byte_ld) |=> !word_st_data[10]);

    assert_byte_upper_R8: assert property (@(posedge clk) disable iff (rst)
        (byte_ld && !word_ld) |=>
        (word_st_data[31:8] == $past(word_st_data[31:8]) || model_lvl != $past(model_lvl)));

    assert_half_upper_R9: assert property (@(posedge clk) disable iff (rst)
        (word_ld && !word_wide) |=>
        (word_st_data[31:16] == $past(word_st_data[31:16]) || model_lvl != $past(model_lvl)));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!word_ld && !byte_ld && !dir_clr && !dir_set && alu_mask == '0) |=>
        ($stable(word_st_data) || model_lvl != $past(model_lvl)));
endmodule

// File: tb/cpu_status_reg_bench.sv
module cpu_status_reg_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  model_lvl;
    logic [5:0]  alu_mask, alu_flags;
    logic        dir_clr, dir_set, byte_ld, word_ld, word_wide;
    logic [7:0]  byte_ld_data, byte_st_data;
    logic [31:0] word_ld_data, word_st_data;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [31:0] tmp;

    always #4 clk = ~clk;

    cpu_status_reg u_cpu_status_reg (
        .clk(clk), .rst(rst), .model_lvl(model_lvl),
        .alu_mask(alu_mask), .alu_flags(alu_flags),
        .dir_clr(dir_clr), .dir_set(dir_set),
        .byte_ld(byte_ld), .byte_ld_data(byte_ld_data), .byte_st_data(byte_st_data),
        .word_ld(word_ld), .word_wide(word_wide),
        .word_ld_data(word_ld_data), .word_st_data(word_st_data)
    );

    // {level, load data (32-bit), expected store}
    localparam int NV = 12;
    localparam logic [65:0] VEC [NV] = '{
        {2'd0, 32'hFFFF_FFFF, 32'h0000_FFD7},
        {2'd0, 32'h0000_0000, 32'h0000_F002},
        {2'd1, 32'hFFFF_FFFF, 32'h0000_7FD7},
        {2'd1, 32'h0000_8000, 32'h0000_0002},
        {2'd2, 32'hFFFF_FFFF, 32'h001B_7FD7},
        {2'd2, 32'h0004_0000, 32'h0000_0002},
        {2'd3, 32'hFFFF_FFFF, 32'h003F_7FD7},
        {2'd3, 32'h0004_0000, 32'h0004_0002},
        {2'd3, 32'h0020_0000, 32'h0020_0002},
        {2'd2, 32'h0020_0000, 32'h0000_0002},
        {2'd3, 32'hFFC0_0028, 32'h0000_0002},
        {2'd1, 32'h0001_0000, 32'h0000_0002}
    };

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired: actual=%0d expected<=50000 cycles", cyc);
            finish_run();
        end
    end

    task automatic idle();
        alu_mask = '0; alu_flags = '0; dir_clr = 0; dir_set = 0;
        byte_ld = 0; byte_ld_data = '0; word_ld = 0; word_wide = 0; word_ld_data = '0;
    endtask

    // command is held across one rising edge, released and sampled at the next falling edge
    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic [1:0] l);
        model_lvl = l; rst = 1; idle();
        @(negedge clk); @(negedge clk);
        rst = 0;
    endtask

    initial begin
        rst = 1; model_lvl = 0; idle();
        @(negedge clk);
        do_reset(2'd0);
        check("R1 reset level0", word_st_data, 32'h0000_F002);

        // table walk: 32-bit loads at every level
        for (int i = 0; i < NV; i++) begin
            model_lvl = VEC[i][65:64];
            word_ld = 1; word_wide = 1; word_ld_data = VEC[i][63:32];
            tick();
            check($sformatf("R2 R3 R4 R5 R6 vector %0d", i), word_st_data, VEC[i][31:0]);
        end

        do_reset(2'd3);
        check("R1 reset level3", word_st_data, 32'h0000_0002);

        // R10 ALU masked update
        alu_mask = 6'b111111; alu_flags = 6'b101010; tick();
        check("R10 all flags", word_st_data, 32'h0000_0846);
        alu_mask = 6'b000001; alu_flags = 6'b000001; tick();
        check("R10 carry only", word_st_data, 32'h0000_0847);

        // R7 direction commands
        dir_set = 1; tick();
        check("R7 set", word_st_data, 32'h0000_0C47);
        dir_clr = 1; tick();
        check("R7 clear", word_st_data, 32'h0000_0847);
        dir_clr = 1; dir_set = 1; tick();
        check("R7 both set wins", word_st_data, 32'h0000_0C47);

        // R8 byte path
        byte_ld = 1; byte_ld_data = 8'hFF; tick();
        check("R8 byte load", word_st_data, 32'h0000_0CD7);
        check("R8 byte store", {24'h0, byte_st_data}, 32'h0000_00D7);

        // R9 half and full loads
        word_ld = 1; word_wide = 1; word_ld_data = 32'h003F_0000; tick();
        check("R9 wide load", word_st_data, 32'h003F_0002);
        word_ld = 1; word_wide = 0; word_ld_data = 32'h0000_FFFF; tick();
        check("R9 half load ones", word_st_data, 32'h003F_7FD7);
        word_ld = 1; word_wide = 0; word_ld_data = 32'hFFFF_0000; tick();
        check("R9 half load zeros", word_st_data, 32'h003F_0002);

        // R11 priority
        word_ld = 1; word_wide = 1; word_ld_data = 32'h0000_0001;
        byte_ld = 1; byte_ld_data = 8'h00; dir_set = 1;
        alu_mask = 6'b111111; alu_flags = 6'b111111; tick();
        check("R11 word wins", word_st_data, 32'h0000_0003);
        byte_ld = 1; byte_ld_data = 8'h40; dir_set = 1;
        alu_mask = 6'b111111; alu_flags = 6'b111111; tick();
        check("R11 byte over dir and alu", word_st_data, 32'h0000_0042);
        dir_set = 1; alu_mask = 6'b000001; alu_flags = 6'b000001; tick();
        check("R11 dir over alu", word_st_data, 32'h0000_0442);
        tick();
        check("R11 idle hold", word_st_data, 32'h0000_0442);

        // R12 toggle through store/xor/load
        tmp = word_st_data;
        word_ld = 1; word_wide = 1; word_ld_data = tmp ^ 32'h0000_0400; tick();
        check("R12 toggle once", word_st_data, 32'h0000_0042);
        tmp = word_st_data;
        word_ld = 1; word_wide = 1; word_ld_data = tmp ^ 32'h0000_0400; tick();
        check("R12 toggle back", word_st_data, 32'h0000_0442);

        // R3 level 0 writes to 15:12 ignored
        do_reset(2'd0);
        word_ld = 1; word_wide = 0; word_ld_data = 32'h0000_0000; tick();
        check("R3 legacy half load", word_st_data, 32'h0000_F002);
        dir_set = 1; tick();
        check("R3 R7 legacy dir set", word_st_data, 32'h0000_F402);

        // R4 privilege field writable at level 1
        do_reset(2'd1);
        word_ld = 1; word_wide = 0; word_ld_data = 32'h0000_3000; tick();
        check("R4 privilege field", word_st_data, 32'h0000_3002);

        finish_run();
    end
endmodule